// File: doc/BRIEF.md
# Dual-Channel Converter Command Receiver

This block is the digital front end of a two-channel 8-bit converter. A host shifts 16-bit command words in over a three-wire serial link: an active-low frame select, a serial clock and a data line. The block oversamples those three pins with its own system clock, assembles each word, and decodes it into register writes. Those writes go to a shared staging register and to the two output code registers, A and B.

The staging register lets the host preload channel B and later commit it in the same cycle that channel A takes a new code. Both analog outputs then move together. Every completed word also carries a fast-settling flag and a power-down flag, which the block keeps and presents as outputs. The system clock must run at least four times faster than the serial clock.

Top module: `dac_serial_ctrl`

## Requirements
- R1: After synchronous reset both codes, the staging register, the fast flag and the power-down flag are all zero.
- R2: While the frame select is low, one data bit is taken on each falling serial-clock edge, most significant bit first. In the 16-bit word, bits 15 and 12 form the select field {bit15,bit12}, bit 14 is the fast flag, bit 13 is the power-down flag, bits 11..4 are the code and bits 3..0 are ignored.
- R3: Select 00 loads the code into the staging register and into code B. Code A is unchanged.
- R4: Select 01 loads the code into the staging register only. Neither output code changes.
- R5: Select 10 loads the code into code A and copies the staging register into code B in the same clock cycle.
- R6: Select 11 leaves both codes and the staging register unchanged.
- R7: Every completed word, select 11 included, sets the fast flag from bit 14 and the power-down flag from bit 13.
- R8: A frame that ends with fewer than 16 bits is completed on the rising frame select. The received bits form the low end of the word and the missing high bits are zero.
- R9: After the 16th bit the word is completed at once. Further clock edges in the same frame are ignored until the frame select falls again.
- R10: A frame with no clock edges has no effect.
- R11: The outputs change only in the cycle after a word completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame select from the host |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| code_a | output | 8 | Channel A output code |
| code_b | output | 8 | Channel B output code |
| fast_mode | output | 1 | Fast-settling flag |
| power_down | output | 1 | Power-down flag |

## Verification
The assertions check on every cycle that the bit counter never exceeds a word and that a completion is a single-cycle pulse. They also check that a staging-only or reserved word leaves both codes alone, that a commit word moves A and B together from the right sources, and that the outputs hold between completions. The way a word is decoded depends on serial framing, and only the bench scenarios show it: MSB-first assembly, zero extension of short frames, discarding of bits after the 16th, and empty frames. The bench also shows chained sequences, in which B is staged by one word and committed by a later one.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    SEL_LOAD_B  = 2'b00,
    SEL_STAGE   = 2'b01,
    SEL_COMMIT  = 2'b10,
    SEL_RSVD    = 2'b11
  } sel_e;

  function automatic sel_e word_sel(input logic [WORD_W-1:0] w);
    return sel_e'({w[15], w[12]});
  endfunction

  function automatic logic [CODE_W-1:0] word_code(input logic [WORD_W-1:0] w);
    return w[11:4];
  endfunction
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dsc_shifter.sv
module dsc_shifter #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              frame_s,
  input  logic              din_s,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  logic              sclk_q, frame_q, full;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;
  logic              sclk_fall, frame_fall, frame_rise;

  assign sclk_fall  = sclk_q & ~sclk_s;
  assign frame_fall = frame_q & ~frame_s;
  assign frame_rise = ~frame_q & frame_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      frame_q <= 1'b0;
      full    <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      done    <= 1'b0;
      word    <= '0;
    end else begin
      sclk_q  <= sclk_s;
      frame_q <= frame_s;
      done    <= 1'b0;
      if (frame_fall) begin
        cnt  <= '0;
        sh   <= '0;
        full <= 1'b0;
      end else if (frame_rise) begin
        if (cnt != '0 && !full) begin
          done <= 1'b1;
          word <= sh;
        end
        cnt <= '0;
      end else if (!frame_s && sclk_fall && !full) begin
        sh  <= {sh[WORD_W-2:0], din_s};
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(WORD_W - 1)) begin
          full <= 1'b1;
          done <= 1'b1;
          word <= {sh[WORD_W-2:0], din_s};
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(WORD_W)) else $error("bit count overflow"); // R2
  AST_FULL_STOP: assert property (@(posedge clk) disable iff (rst)
    (full && !frame_fall && !frame_rise) |=> $stable(sh)) else $error("bits taken after full word"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("completion not a single pulse"); // R11
endmodule

// File: rtl/dsc_regfile.sv
module dsc_regfile
  import dsc_pkg::*;
#(
  parameter int WORD_W = dsc_pkg::WORD_W,
  parameter int CODE_W = dsc_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              fast_mode,
  output logic              power_down
);
  logic [CODE_W-1:0] stage;
  sel_e              sel;
  logic [CODE_W-1:0] code;

  assign sel  = word_sel(word);
  assign code = word_code(word);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage      <= '0;
      code_a     <= '0;
      code_b     <= '0;
      fast_mode  <= 1'b0;
      power_down <= 1'b0;
    end else if (valid) begin
      fast_mode  <= word[14];
      power_down <= word[13];
      unique case (sel)
        SEL_LOAD_B: begin
          stage  <= code;
          code_b <= code;
        end
        SEL_STAGE:  stage <= code;
        SEL_COMMIT: begin
          code_a <= code;
          code_b <= stage;
        end
        SEL_RSVD: ;
      endcase
    end
  end

  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (valid && sel == SEL_STAGE) |=> ($stable(code_a) && $stable(code_b))) else $error("stage word moved a code"); // R4
  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && sel == SEL_RSVD) |=> ($stable(code_a) && $stable(code_b) && $stable(stage))) else $error("reserved word changed state"); // R6
  AST_COMMIT_PAIR: assert property (@(posedge clk) disable iff (rst)
    (valid && sel == SEL_COMMIT) |=> (code_a == $past(code) && code_b == $past(stage))) else $error("commit mismatch"); // R5
  AST_LOAD_B: assert property (@(posedge clk) disable iff (rst)
    (valid && sel == SEL_LOAD_B) |=> ($stable(code_a) && code_b == $past(code))) else $error("load B mismatch"); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(code_a) && $stable(code_b) && $stable(fast_mode) && $stable(power_down))) else $error("output moved without a word"); // R11
endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
  import dsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              fast_mode,
  output logic              power_down
);
  logic [2:0]        pins_s;
  logic              done;
  logic [WORD_W-1:0] word;

  dsc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({frame_n, ser_clk, ser_din}),
    .q   (pins_s)
  );

  dsc_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (pins_s[1]),
    .frame_s (pins_s[2]),
    .din_s   (pins_s[0]),
    .done    (done),
    .word    (word)
  );

  dsc_regfile #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .valid      (done),
    .word       (word),
    .code_a     (code_a),
    .code_b     (code_b),
    .fast_mode  (fast_mode),
    .power_down (power_down)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (code_a == '0 && code_b == '0 && !fast_mode && !power_down)) else $error("reset state wrong"); // R1
endmodule

// File: tb/dac_serial_ctrl_bench.sv
module dac_serial_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic [7:0] code_a, code_b;
  logic fast_mode, power_down;
  int checks = 0, fails = 0;
  bit timed_out = 1'b0;

  always #10 clk = ~clk;

  dac_serial_ctrl u_dac_serial_ctrl (
    .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .code_a(code_a), .code_b(code_b), .fast_mode(fast_mode), .power_down(power_down)
  );

  // {word, expected A, expected B, fast, power-down}
  localparam int NV = 9;
  localparam logic [33:0] VEC [NV] = '{
    {16'h45A0, 8'h00, 8'h5A, 1'b1, 1'b0},  // R3 load B, stage 5A
    {16'h13C0, 8'h00, 8'h5A, 1'b0, 1'b0},  // R4 stage 3C
    {16'hCC30, 8'hC3, 8'h3C, 1'b1, 1'b0},  // R5 commit
    {16'hBFF0, 8'hC3, 8'h3C, 1'b0, 1'b1},  // R6 reserved, R7 flags
    {16'h1810, 8'hC3, 8'h3C, 1'b0, 1'b0},  // R4 stage 81
    {16'h0000, 8'hC3, 8'h00, 1'b0, 1'b0},  // R3 zero code
    {16'h8FF0, 8'hFF, 8'h00, 1'b0, 1'b0},  // R5 commit staged zero
    {16'h7770, 8'hFF, 8'h00, 1'b1, 1'b1},  // R4 stage 77, R7
    {16'h8120, 8'h12, 8'h77, 1'b0, 1'b0}   // R5 commit 77
  };

  task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got a=%h b=%h f=%b p=%b, expected a=%h b=%h f=%b p=%b",
               req, got[17:10], got[9:2], got[1], got[0], exp[17:10], exp[9:2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [17:0] outs();
    return {code_a, code_b, fast_mode, power_down};
  endfunction

  task automatic send(input logic [31:0] bits, input int n);
    frame_n = 1'b0;
    repeat (6) @(posedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_clk = 1'b1; ser_din = bits[i];
      repeat (4) @(posedge clk);
      ser_clk = 1'b0;
      repeat (4) @(posedge clk);
    end
    repeat (4) @(posedge clk);
    frame_n = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    timed_out = 1'b1;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    rst = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", outs(), 18'h0);

    for (int v = 0; v < NV; v++) begin
      send({16'h0, VEC[v][33:18]}, 16);
      chk($sformatf("R2 vector %0d (R3/R4/R5/R6/R7)", v), outs(), VEC[v][17:0]);
      if (timed_out) break;
    end

    // R8: 12-bit frame -> 0x08AB, select 00, code 8A
    send(32'h08AB, 12);
    chk("R8 short frame", outs(), {8'h12, 8'h8A, 2'b00});

    // R9: 20 bits, first 16 = 8550 commit; trailing ones ignored
    send(32'h8550F, 20);
    chk("R9 extra bits ignored", outs(), {8'h55, 8'h8A, 2'b00});

    // R10: empty frame
    send(32'h0, 0);
    chk("R10 empty frame", outs(), {8'h55, 8'h8A, 2'b00});

    // R11: mid-frame, outputs unchanged before completion
    frame_n = 1'b0;
    repeat (6) @(posedge clk);
    for (int i = 7; i >= 0; i--) begin
      ser_clk = 1'b1; ser_din = 1'b1;
      repeat (4) @(posedge clk);
      ser_clk = 1'b0;
      repeat (4) @(posedge clk);
    end
    @(negedge clk);
    chk("R11 no change mid-frame", outs(), {8'h55, 8'h8A, 2'b00});
    frame_n = 1'b1;   // 8 ones -> word 0x00FF, select 00, code 0F
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R8 short frame of ones", outs(), {8'h55, 8'h0F, 2'b00});

    // R6 with R7: reserved word sets flags only
    send(32'hDAB0, 16);
    chk("R6 reserved keeps codes, R7 flags", outs(), {8'h55, 8'h0F, 2'b10});

    // R1: reset again clears all
    rst = 1'b1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset after activity", outs(), 18'h0);

    // R5: staging cleared by reset, commit gives B=0
    send(32'h8990, 16);
    chk("R5 commit after reset", outs(), {8'h99, 8'h00, 2'b00});

    if (timed_out) begin
      checks++; fails++;
      $display("FAIL R11 watchdog: got timeout, expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule